// File: doc/BRIEF.md
# DMA channel termination controller

This block holds the activity flag of one DMA channel and decides when that channel stops. Software starts the channel by writing 1 to its active bit. A small sequencer then runs transfer units from incoming requests: a read phase followed by a write phase when two addresses are used, or a write phase alone in single-address operation. In block operation one request runs a whole block of units back to back. The block tracks a transfer counter and a source and a destination address. Each address can be confined to a power-of-two repeat window.

The channel stops for one of three reasons: the transfer counter steps from 1 to 0, an address wraps out of its repeat window while that window's interrupt enable is set, or software writes 0 to the active bit. Each reason takes effect at its own point. A counter end stops at once. A repeat wrap or a software stop lets the unit in progress finish, or the whole block in block operation. The active flag keeps reading 1 until that pending work is done. An interrupt flag records counter ends (when enabled) and repeat-window ends, and it drives a level interrupt request.

Bus timing, arbitration between channels and the register file are outside this block. Loads and mode inputs are expected to change only while the channel is inactive.

Top module: `dma_chan_stop_ctrl`

## Requirements
- R1: After reset, `active`, `irq_flag` and `irq` are 0 and both addresses are 0.
- R2: A pulse on `act_wr` with `act_wr_val`=1 while inactive sets `active` on the next edge. Outside block operation the counter decrements on each completed write phase. The completion that steps it from 1 to 0 clears `active` at that edge, and it sets `irq_flag` only if `cnt_ie` is 1.
- R3: In block operation one accepted request runs `blk_size` units (`blk_size` of 1 or more) with no further request. The counter decrements once per completed block, only its low LOW_W bits (default 16) change, and the end is taken when those low bits step from 1 to 0, whatever the upper bits hold.
- R4: A counter that holds 0 when a unit completes wraps to all ones and does not stop the channel.
- R5: The source address steps on each read completion when `dual_mode`=1, and on each write completion when `dual_mode`=0. The destination address steps on each write completion. A step adds 1 inside the window given by the set bits of the mask and wraps to the window base from its top. A mask of 0 means a plain increment.
- R6: A wrap of an address whose repeat enable (`src_rie`/`dst_rie`) is 1 ends the transfer after the current unit completes. A wrap on a read phase still lets the following write phase complete. On that end `irq_flag` is set. A wrap with the enable at 0 has no effect on `active`.
- R7: In block operation, a repeat-window end or a software stop raised partway through a block takes effect only when the block's last write completes. `active` stays 1 until then.
- R8: A software stop (`act_wr` with `act_wr_val`=0) issued while a unit is accepted keeps `active` at 1 until that unit's write completes, then clears it. Issued with no unit accepted, it clears `active` on the next edge, and a request in that same cycle is not accepted.
- R9: `irq` is 1 exactly while `irq_flag` is 1 and at least one of `cnt_ie`, `src_rie`, `dst_rie` is 1. A pulse on `irq_clr` clears `irq_flag`. A set in the same cycle wins over the clear.
- R10: A software stop written in the same cycle as the write completion that steps the counter from 1 to 0 produces a single end. `active` clears at that edge and stays 0, and `irq_flag` follows `cnt_ie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| act_wr | input | 1 | Software write strobe for the active bit |
| act_wr_val | input | 1 | Value written to the active bit |
| cnt_ld | input | 1 | Load strobe for the transfer counter |
| cnt_ld_val | input | CNT_W | Transfer counter load value |
| addr_ld | input | 1 | Load strobe for both addresses |
| src_ld_val | input | ADDR_W | Source address load value |
| dst_ld_val | input | ADDR_W | Destination address load value |
| blk_mode | input | 1 | 1 selects block operation |
| dual_mode | input | 1 | 1 selects a read phase before each write phase |
| blk_size | input | BLK_W | Units per block |
| src_mask | input | ADDR_W | Source repeat-window mask (0 = none) |
| dst_mask | input | ADDR_W | Destination repeat-window mask (0 = none) |
| src_rie | input | 1 | End on source window wrap |
| dst_rie | input | 1 | End on destination window wrap |
| cnt_ie | input | 1 | Flag counter ends |
| irq_clr | input | 1 | Clear strobe for the interrupt flag |
| req | input | 1 | Transfer request |
| rd_done | input | 1 | Read phase completes this cycle |
| wr_done | input | 1 | Write phase completes this cycle |
| active | output | 1 | Channel active flag |
| irq_flag | output | 1 | Interrupt flag |
| irq | output | 1 | Interrupt request |
| src_addr | output | ADDR_W | Current source address |
| dst_addr | output | ADDR_W | Current destination address |

## Verification
The software stop and the counter end can meet on one edge. The bench provokes this by raising the stop strobe in the very cycle that the final write of a one-unit count completes. It then checks that `active` falls at that edge, stays low a cycle later instead of being re-armed by a left-over pending stop, and that the flag reflects only the counter-end enable. A repeat wrap can also arrive during a unit whose write is still owed. The bench judges this by sampling `active` right after the wrapping read and again after the write.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_st_e;
endpackage

// File: rtl/dcs_addr_step.sv
module dcs_addr_step #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic [AW-1:0] mask,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          wrap
);
  logic [AW-1:0] addr_nxt;
  logic          at_top;

  always_comb begin
    at_top   = (mask != '0) && ((addr & mask) == mask);
    wrap     = step && at_top;
    addr_nxt = addr;
    if (ld) begin
      addr_nxt = ld_val;
    end else if (step) begin
      if (mask == '0) addr_nxt = addr + AW'(1);
      else            addr_nxt = (addr & ~mask) | ((addr + AW'(1)) & mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            addr <= '0;
    else if (ld || step)   addr <= addr_nxt;
  end
endmodule

// File: rtl/dcs_counter.sv
module dcs_counter #(
  parameter int CW = 24,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          dec,
  input  logic          blk_mode,
  output logic          end_hit
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    end_hit = dec && (blk_mode ? (cnt[LW-1:0] == LW'(1)) : (cnt == CW'(1)));
    cnt_nxt = cnt;
    if (ld) begin
      cnt_nxt = ld_val;
    end else if (dec) begin
      if (blk_mode) cnt_nxt = {cnt[CW-1:LW], cnt[LW-1:0] - LW'(1)};
      else          cnt_nxt = cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (ld || dec) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/dcs_seq.sv
module dcs_seq
  import dcs_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_ok,
  input  logic          req,
  input  logic          dual_mode,
  input  logic          blk_mode,
  input  logic [BW-1:0] blk_size,
  input  logic          rd_done,
  input  logic          wr_done,
  output logic          busy,
  output logic          rd_fire,
  output logic          unit_done,
  output logic          blk_end
);
  seq_st_e       st, st_nxt;
  logic [BW-1:0] bcnt, bcnt_nxt;
  logic          last_unit;
  seq_st_e       first_st;

  always_comb begin
    first_st  = dual_mode ? ST_RD : ST_WR;
    last_unit = !blk_mode || (bcnt <= BW'(1));
    rd_fire   = (st == ST_RD) && rd_done;
    unit_done = (st == ST_WR) && wr_done;
    blk_end   = unit_done && last_unit;
    busy      = (st != ST_IDLE);
    st_nxt    = st;
    bcnt_nxt  = bcnt;
    case (st)
      ST_IDLE: if (accept_ok && req) begin
        st_nxt   = first_st;
        bcnt_nxt = blk_size;
      end
      ST_RD: if (rd_done) st_nxt = ST_WR;
      ST_WR: if (wr_done) begin
        if (last_unit) begin
          st_nxt = ST_IDLE;
        end else begin
          st_nxt   = first_st;
          bcnt_nxt = bcnt - BW'(1);
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      bcnt <= '0;
    end else begin
      st   <= st_nxt;
      bcnt <= bcnt_nxt;
    end
  end
endmodule

// File: rtl/dma_chan_stop_ctrl.sv
module dma_chan_stop_ctrl #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 24,
  parameter int LOW_W  = 16,
  parameter int BLK_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_wr,
  input  logic              act_wr_val,
  input  logic              cnt_ld,
  input  logic [CNT_W-1:0]  cnt_ld_val,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] src_ld_val,
  input  logic [ADDR_W-1:0] dst_ld_val,
  input  logic              blk_mode,
  input  logic              dual_mode,
  input  logic [BLK_W-1:0]  blk_size,
  input  logic [ADDR_W-1:0] src_mask,
  input  logic [ADDR_W-1:0] dst_mask,
  input  logic              src_rie,
  input  logic              dst_rie,
  input  logic              cnt_ie,
  input  logic              irq_clr,
  input  logic              req,
  input  logic              rd_done,
  input  logic              wr_done,
  output logic              active,
  output logic              irq_flag,
  output logic              irq,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr
);
  localparam int NADDR = 2;

  logic [1:0] rst_sync;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  logic seq_busy, rd_fire, unit_done, blk_end, accept_ok, cnt_end;
  logic stop_pend, stop_pend_nxt, rpt_pend, rpt_pend_nxt;
  logic active_nxt, flag_nxt;
  logic sw_stop_wr, sw_start, rpt_now, rpt_any, boundary_stop, idle_stop, end_now, flag_set;

  logic [NADDR-1:0][ADDR_W-1:0] a_ld_val, a_mask, a_addr;
  logic [NADDR-1:0]             a_step, a_wrap;

  assign a_ld_val  = {dst_ld_val, src_ld_val};
  assign a_mask    = {dst_mask, src_mask};
  assign a_step[0] = dual_mode ? rd_fire : unit_done;
  assign a_step[1] = unit_done;
  assign src_addr  = a_addr[0];
  assign dst_addr  = a_addr[1];

  for (genvar g = 0; g < NADDR; g++) begin : g_addr
    dcs_addr_step #(.AW(ADDR_W)) u_step (
      .clk    (clk),
      .rst_n  (rst_n_i),
      .ld     (addr_ld),
      .ld_val (a_ld_val[g]),
      .mask   (a_mask[g]),
      .step   (a_step[g]),
      .addr   (a_addr[g]),
      .wrap   (a_wrap[g])
    );
  end

  dcs_counter #(.CW(CNT_W), .LW(LOW_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .ld       (cnt_ld),
    .ld_val   (cnt_ld_val),
    .dec      (blk_mode ? blk_end : unit_done),
    .blk_mode (blk_mode),
    .end_hit  (cnt_end)
  );

  dcs_seq #(.BW(BLK_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .accept_ok (accept_ok),
    .req       (req),
    .dual_mode (dual_mode),
    .blk_mode  (blk_mode),
    .blk_size  (blk_size),
    .rd_done   (rd_done),
    .wr_done   (wr_done),
    .busy      (seq_busy),
    .rd_fire   (rd_fire),
    .unit_done (unit_done),
    .blk_end   (blk_end)
  );

  always_comb begin
    sw_stop_wr    = act_wr && !act_wr_val;
    sw_start      = act_wr && act_wr_val && !active;
    accept_ok     = active && !stop_pend && !sw_stop_wr;
    rpt_now       = (a_wrap[0] && src_rie) || (a_wrap[1] && dst_rie);
    rpt_any       = rpt_pend || rpt_now;
    boundary_stop = blk_end && (rpt_any || stop_pend || sw_stop_wr);
    idle_stop     = sw_stop_wr && !seq_busy;
    end_now       = active && (cnt_end || boundary_stop || idle_stop);
    flag_set      = active && ((cnt_end && cnt_ie) || (blk_end && rpt_any));

    active_nxt = active;
    if (sw_start)     active_nxt = 1'b1;
    else if (end_now) active_nxt = 1'b0;

    stop_pend_nxt = stop_pend;
    if (sw_start || end_now)                     stop_pend_nxt = 1'b0;
    else if (sw_stop_wr && active && seq_busy)   stop_pend_nxt = 1'b1;

    rpt_pend_nxt = rpt_pend;
    if (sw_start || end_now)    rpt_pend_nxt = 1'b0;
    else if (rpt_now && active) rpt_pend_nxt = 1'b1;

    flag_nxt = irq_flag;
    if (flag_set)     flag_nxt = 1'b1;
    else if (irq_clr) flag_nxt = 1'b0;

    irq = irq_flag && (cnt_ie || src_rie || dst_rie);
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      active    <= 1'b0;
      stop_pend <= 1'b0;
      rpt_pend  <= 1'b0;
      irq_flag  <= 1'b0;
    end else begin
      active    <= active_nxt;
      stop_pend <= stop_pend_nxt;
      rpt_pend  <= rpt_pend_nxt;
      irq_flag  <= flag_nxt;
    end
  end
endmodule

// File: rtl/dcs_chk.sv
module dcs_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          active,
  input logic          seq_busy,
  input logic          stop_pend,
  input logic          unit_done,
  input logic          blk_end,
  input logic          cnt_end,
  input logic          irq_flag,
  input logic          addr_ld,
  input logic          src_step,
  input logic          dst_step,
  input logic [AW-1:0] src_mask,
  input logic [AW-1:0] dst_mask,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr
);
  // R8
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !seq_busy);

  // R2
  cnt_end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_end |=> !active);

  // R7
  mid_block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !blk_end) |=> active);

  // R8
  stop_pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pend && !blk_end) |=> active);

  // R9
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(active));

  // R5
  src_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_step && !addr_ld && src_mask != '0) |=>
      ((src_addr & ~$past(src_mask)) == ($past(src_addr) & ~$past(src_mask))));

  // R5
  dst_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_step && !addr_ld && dst_mask != '0) |=>
      ((dst_addr & ~$past(dst_mask)) == ($past(dst_addr) & ~$past(dst_mask))));
endmodule

bind dma_chan_stop_ctrl dcs_chk #(.AW(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_i),
  .active    (active),
  .seq_busy  (seq_busy),
  .stop_pend (stop_pend),
  .unit_done (unit_done),
  .blk_end   (blk_end),
  .cnt_end   (cnt_end),
  .irq_flag  (irq_flag),
  .addr_ld   (addr_ld),
  .src_step  (a_step[0]),
  .dst_step  (a_step[1]),
  .src_mask  (src_mask),
  .dst_mask  (dst_mask),
  .src_addr  (src_addr),
  .dst_addr  (dst_addr)
);

// File: tb/tb_dma_chan_stop_ctrl.sv
`timescale 1ns/1ps
module tb_dma_chan_stop_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        act_wr, act_wr_val, cnt_ld, addr_ld;
  logic [23:0] cnt_ld_val;
  logic [15:0] src_ld_val, dst_ld_val, src_mask, dst_mask;
  logic        blk_mode, dual_mode, src_rie, dst_rie, cnt_ie, irq_clr;
  logic [7:0]  blk_size;
  logic        req, rd_done, wr_done;
  logic        active, irq_flag, irq;
  logic [15:0] src_addr, dst_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dma_chan_stop_ctrl dut (
    .clk(clk), .rst_n(rst_n), .act_wr(act_wr), .act_wr_val(act_wr_val),
    .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val), .addr_ld(addr_ld),
    .src_ld_val(src_ld_val), .dst_ld_val(dst_ld_val), .blk_mode(blk_mode),
    .dual_mode(dual_mode), .blk_size(blk_size), .src_mask(src_mask),
    .dst_mask(dst_mask), .src_rie(src_rie), .dst_rie(dst_rie), .cnt_ie(cnt_ie),
    .irq_clr(irq_clr), .req(req), .rd_done(rd_done), .wr_done(wr_done),
    .active(active), .irq_flag(irq_flag), .irq(irq),
    .src_addr(src_addr), .dst_addr(dst_addr)
  );

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cfg(input logic [23:0] cnt, input logic [15:0] sb, input logic [15:0] db,
                     input logic [15:0] sm, input logic [15:0] dm, input logic sr, input logic dr,
                     input logic ci, input logic bm, input logic dl, input logic [7:0] bs);
    cnt_ld_val = cnt; src_ld_val = sb; dst_ld_val = db; src_mask = sm; dst_mask = dm;
    src_rie = sr; dst_rie = dr; cnt_ie = ci; blk_mode = bm; dual_mode = dl; blk_size = bs;
    cnt_ld = 1'b1; addr_ld = 1'b1;
    tick();
    cnt_ld = 1'b0; addr_ld = 1'b0; act_wr = 1'b1; act_wr_val = 1'b1;
    tick();
    act_wr = 1'b0;
  endtask

  task automatic req_pulse();
    req = 1'b1; tick(); req = 1'b0;
  endtask
  task automatic rd_pulse();
    rd_done = 1'b1; tick(); rd_done = 1'b0;
  endtask
  task automatic wr_pulse();
    wr_done = 1'b1; tick(); wr_done = 1'b0;
  endtask
  task automatic unit(input logic dl);
    req_pulse();
    if (dl) rd_pulse();
    wr_pulse();
  endtask
  task automatic sw_stop();
    act_wr = 1'b1; act_wr_val = 1'b0; tick(); act_wr = 1'b0;
  endtask
  task automatic cleanup();
    if (active) sw_stop();
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 active", 32'(active), 0);
    check("R1 irq_flag", 32'(irq_flag), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 src_addr", 32'(src_addr), 0);
    check("R1 dst_addr", 32'(dst_addr), 0);
  endtask

  task automatic t_cnt_end();
    cfg(24'd3, 16'h0010, 16'h0040, 16'h0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1);
    check("R2 started", 32'(active), 1);
    unit(1'b0); unit(1'b0);
    check("R2 still active", 32'(active), 1);
    check("R5 src single", 32'(src_addr), 32'h12);
    check("R5 dst single", 32'(dst_addr), 32'h42);
    unit(1'b0);
    check("R2 end active", 32'(active), 0);
    check("R2 end flag", 32'(irq_flag), 1);
    check("R9 irq on", 32'(irq), 1);
    cnt_ie = 1'b0; #1;
    check("R9 irq masked", 32'(irq), 0);
    check("R9 flag kept", 32'(irq_flag), 1);
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    check("R9 flag cleared", 32'(irq_flag), 0);
  endtask

  task automatic t_cnt_end_noie();
    cfg(24'd1, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1);
    unit(1'b0);
    check("R2 end no ie active", 32'(active), 0);
    check("R2 end no ie flag", 32'(irq_flag), 0);
    cleanup();
  endtask

  task automatic t_zero_start();
    cfg(24'd0, 16'h0020, 16'h0060, 16'h0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1);
    unit(1'b0); unit(1'b0); unit(1'b0);
    check("R4 zero start keeps running", 32'(active), 1);
    check("R4 no flag", 32'(irq_flag), 0);
    act_wr = 1'b1; act_wr_val = 1'b0; req = 1'b1;
    tick();
    act_wr = 1'b0; req = 1'b0;
    check("R8 idle stop", 32'(active), 0);
    wr_pulse();
    check("R8 request in stop cycle ignored", 32'(dst_addr), 32'h63);
    cleanup();
  endtask

  task automatic t_block_low();
    cfg(24'h010002, 16'h0300, 16'h0500, 16'h0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd3);
    req_pulse();
    for (int i = 0; i < 3; i++) begin rd_pulse(); wr_pulse(); end
    check("R3 after block 1 active", 32'(active), 1);
    check("R3 src after block 1", 32'(src_addr), 32'h303);
    check("R3 dst after block 1", 32'(dst_addr), 32'h503);
    req_pulse();
    for (int i = 0; i < 3; i++) begin rd_pulse(); wr_pulse(); end
    check("R3 low bits end", 32'(active), 0);
    check("R3 flag", 32'(irq_flag), 1);
    cleanup();
  endtask

  task automatic t_rpt_read();
    cfg(24'd100, 16'h0102, 16'h0700, 16'h0003, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd1);
    unit(1'b1);
    check("R5 src dual step", 32'(src_addr), 32'h103);
    req_pulse(); rd_pulse();
    check("R5 src wraps to base", 32'(src_addr), 32'h100);
    check("R6 write still owed", 32'(active), 1);
    wr_pulse();
    check("R6 end after write", 32'(active), 0);
    check("R6 flag", 32'(irq_flag), 1);
    check("R6 write done", 32'(dst_addr), 32'h702);
    cleanup();
  endtask

  task automatic t_rpt_block();
    cfg(24'd50, 16'h0000, 16'h0200, 16'h0, 16'h0001, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd4);
    req_pulse(); wr_pulse(); wr_pulse();
    check("R7 wrap mid block active", 32'(active), 1);
    check("R5 dst wrap", 32'(dst_addr), 32'h200);
    wr_pulse();
    check("R7 third unit active", 32'(active), 1);
    wr_pulse();
    check("R7 end at boundary", 32'(active), 0);
    check("R7 flag", 32'(irq_flag), 1);
    cleanup();
  endtask

  task automatic t_rpt_off();
    cfg(24'd10, 16'h0000, 16'h0000, 16'h0001, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1);
    unit(1'b0); unit(1'b0); unit(1'b0);
    check("R6 wrap no enable active", 32'(active), 1);
    check("R6 wrap no enable addr", 32'(src_addr), 1);
    check("R6 wrap no enable flag", 32'(irq_flag), 0);
    cleanup();
  endtask

  task automatic t_sw_mid();
    cfg(24'd10, 16'h0, 16'h0800, 16'h0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1);
    req_pulse(); sw_stop();
    check("R8 reads 1 while pending", 32'(active), 1);
    tick();
    check("R8 still 1", 32'(active), 1);
    wr_pulse();
    check("R8 stop after write", 32'(active), 0);
    check("R8 no flag", 32'(irq_flag), 0);
    check("R8 write done", 32'(dst_addr), 32'h801);
    cleanup();
  endtask

  task automatic t_sw_block();
    cfg(24'd10, 16'h0, 16'h0900, 16'h0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd3);
    req_pulse(); wr_pulse(); sw_stop();
    check("R7 sw stop mid block", 32'(active), 1);
    wr_pulse();
    check("R7 sw stop second unit", 32'(active), 1);
    wr_pulse();
    check("R7 sw stop at boundary", 32'(active), 0);
    check("R7 block finished", 32'(dst_addr), 32'h903);
    cleanup();
  endtask

  task automatic t_coincide();
    cfg(24'd1, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1);
    req_pulse();
    act_wr = 1'b1; act_wr_val = 1'b0; wr_done = 1'b1;
    tick();
    act_wr = 1'b0; wr_done = 1'b0;
    check("R10 single end", 32'(active), 0);
    check("R10 flag", 32'(irq_flag), 1);
    tick();
    check("R10 stays off", 32'(active), 0);
    cleanup();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    rst_n = 1'b0;
    act_wr = 0; act_wr_val = 0; cnt_ld = 0; addr_ld = 0; cnt_ld_val = '0;
    src_ld_val = '0; dst_ld_val = '0; src_mask = '0; dst_mask = '0;
    blk_mode = 0; dual_mode = 0; src_rie = 0; dst_rie = 0; cnt_ie = 0;
    irq_clr = 0; blk_size = 8'd1; req = 0; rd_done = 0; wr_done = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_cnt_end();
    t_cnt_end_noie();
    t_zero_start();
    t_block_low();
    t_rpt_read();
    t_rpt_block();
    t_rpt_off();
    t_sw_mid();
    t_sw_block();
    t_coincide();
    report();
  end
endmodule